// File: doc/BRIEF.md
# Vector Instruction Prefix Classifier

This block looks at a window of machine-code bytes that starts at the first byte of one instruction and works out which vector prefix, if any, the instruction carries. It sorts the instruction into one of four encoding classes (plain legacy, two-byte VEX, three-byte VEX, four-byte EVEX). It reports how many prefix bytes there are and where the opcode byte sits. It also reports whether the register operand reaches into the upper register bank, which only EVEX can address.

It also finds the memory displacement. To do this it reads the mode and r/m fields of the ModRM byte that follows the opcode, plus the SIB base field where a SIB byte is present. It then reports the displacement as a signed 32-bit byte offset. An EVEX instruction with an 8-bit displacement stores that displacement in units of the operand element, so the block multiplies it by the element size given on a side input. Every other encoding, and every 32-bit displacement, is passed through as a plain byte count. A front-end decoder uses the block to learn the address offset and the opcode position before full decode. The results are registered and arrive one clock after the input strobe.

Top module: `vec_prefix_classifier`

## Requirements
- R1: A first byte of 0xC5 gives class code 1 (two-byte VEX), a prefix length of 2 and an opcode offset of 2.
- R2: A first byte of 0xC4 gives class code 2 (three-byte VEX), a prefix length of 3 and an opcode offset of 3.
- R3: A first byte of 0x62 gives class code 3 (EVEX), a prefix length of 4 and an opcode offset of 4, so the opcode is the byte straight after the prefix.
- R4: Any other first byte gives class code 0 (legacy), a prefix length of 0 and an opcode offset of 0.
- R5: The ModRM byte is the byte after the opcode. Mode bits [7:6] = 01 select a 1-byte displacement. Mode 10 selects a 4-byte displacement. Mode 00 with r/m bits [2:0] = 101 also selects a 4-byte displacement. An r/m of 100 with a mode other than 11 inserts one SIB byte before the displacement, and mode 00 with SIB base bits [2:0] = 101 then selects a 4-byte displacement. Every other combination has no displacement: the size output is 0 and the displacement output is 0.
- R6: For class 3 with a 1-byte displacement, the output equals that byte sign-extended to 32 bits and shifted left by the element-size input (log2 of the element size in bytes).
- R7: For classes 0, 1 and 2, a 1-byte displacement is output sign-extended and unscaled, whatever the element-size input.
- R8: A 4-byte displacement is taken little-endian and output unchanged in every class, whatever the element-size input.
- R9: The upper-bank flag is 1 only for class 3 when bit 4 of the second prefix byte is 0. It is 0 otherwise.
- R10: The output strobe rises exactly one clock after an accepted input. While the input strobe is low, every output field holds its value. After reset the strobe is low and every field is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Window holds an instruction start |
| in_win | input | 8*WIN_BYTES (128) | Byte window, byte 0 in bits [7:0] |
| in_elem_log2 | input | 3 | log2 of operand element size in bytes |
| out_valid | output | 1 | Result strobe, one clock after in_valid |
| out_class | output | 2 | 0 legacy, 1 two-byte VEX, 2 three-byte VEX, 3 EVEX |
| out_pfx_len | output | 3 | Prefix length in bytes |
| out_op_off | output | 3 | Byte offset of the opcode |
| out_disp_size | output | 3 | Displacement bytes in the stream: 0, 1 or 4 |
| out_disp | output | 32 | Effective signed displacement in bytes |
| out_hi_bank | output | 1 | Register operand is in the upper bank |

## Verification
The same memory operand is encoded in several ways that all give a 256-byte offset. These include 32-bit byte counts under VEX and EVEX, and 8-bit values scaled by 4 and by 16 under EVEX. A wrong scale or a wrong source field therefore shows up as a different number. Negative 8-bit values are sent both under EVEX with scaling and under VEX with an element size that must be ignored, which separates sign extension from scaling. Windows with a SIB byte, with RIP-style and SIB-base 32-bit forms, and with register-direct forms check that the displacement is read from the right byte or dropped entirely. EVEX prefixes with the upper-bank bit set and clear, next to VEX prefixes whose same bit is clear, show that the bank flag depends on both the class and the bit. Results are sent back to back and with gaps, and a later window of garbage bytes with the strobe low must leave every output unchanged.

// File: rtl/vpc_pkg.sv
package vpc_pkg;

  typedef enum logic [1:0] {
    ENC_LEGACY = 2'd0,
    ENC_VEX2   = 2'd1,
    ENC_VEX3   = 2'd2,
    ENC_EVEX   = 2'd3
  } enc_class_e;

  typedef enum logic [1:0] {
    DSZ_NONE = 2'd0,
    DSZ_BYTE = 2'd1,
    DSZ_WORD = 2'd2
  } dsz_e;

  localparam logic [7:0] LEAD_VEX2 = 8'hC5;
  localparam logic [7:0] LEAD_VEX3 = 8'hC4;
  localparam logic [7:0] LEAD_EVEX = 8'h62;

  typedef struct packed {
    enc_class_e  cls;
    logic [2:0]  pfx_len;
    logic        hi_bank;
  } pfx_info_t;

endpackage

// File: rtl/vpc_prefix_sniff.sv
module vpc_prefix_sniff
  import vpc_pkg::*;
(
  input  logic [15:0] lead_bytes,
  output pfx_info_t   info
);

  logic [7:0] first_b;
  logic [7:0] second_b;

  assign first_b  = lead_bytes[7:0];
  assign second_b = lead_bytes[15:8];

  always_comb begin
    info = '{cls: ENC_LEGACY, pfx_len: 3'd0, hi_bank: 1'b0};
    case (first_b)
      LEAD_VEX2: begin
        info.cls     = ENC_VEX2;
        info.pfx_len = 3'd2;
      end
      LEAD_VEX3: begin
        info.cls     = ENC_VEX3;
        info.pfx_len = 3'd3;
      end
      LEAD_EVEX: begin
        info.cls     = ENC_EVEX;
        info.pfx_len = 3'd4;
        // extra register bit is stored inverted in the first payload byte
        info.hi_bank = ~second_b[4];
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/vpc_disp_locate.sv
module vpc_disp_locate
  import vpc_pkg::*;
#(
  parameter int WIN_BYTES = 16
) (
  input  logic [8*WIN_BYTES-1:0] win,
  input  logic [2:0]             op_off,
  output dsz_e                   dsz,
  output logic [31:0]            raw_disp
);

  localparam int IDX_W = $clog2(WIN_BYTES);

  logic [7:0] wb [WIN_BYTES];

  for (genvar g = 0; g < WIN_BYTES; g++) begin : g_split
    assign wb[g] = win[8*g +: 8];
  end

  logic [IDX_W-1:0] modrm_idx;
  logic [IDX_W-1:0] disp_idx;
  logic [7:0]       modrm;
  logic [7:0]       sib;
  logic [1:0]       mod_f;
  logic [2:0]       rm_f;
  logic             has_sib;

  always_comb begin
    modrm_idx = IDX_W'(op_off) + IDX_W'(1);
    modrm     = wb[modrm_idx];
    mod_f     = modrm[7:6];
    rm_f      = modrm[2:0];
    has_sib   = (mod_f != 2'b11) && (rm_f == 3'b100);
    sib       = wb[modrm_idx + IDX_W'(1)];
    disp_idx  = modrm_idx + IDX_W'(1) + (has_sib ? IDX_W'(1) : IDX_W'(0));
  end

  always_comb begin
    dsz = DSZ_NONE;
    case (mod_f)
      2'b01: dsz = DSZ_BYTE;
      2'b10: dsz = DSZ_WORD;
      2'b00: begin
        if (rm_f == 3'b101)
          dsz = DSZ_WORD;
        else if (has_sib && (sib[2:0] == 3'b101))
          dsz = DSZ_WORD;
      end
      default: dsz = DSZ_NONE;
    endcase
  end

  assign raw_disp = {wb[disp_idx + IDX_W'(3)], wb[disp_idx + IDX_W'(2)],
                     wb[disp_idx + IDX_W'(1)], wb[disp_idx]};

endmodule

// File: rtl/vpc_disp_scale.sv
module vpc_disp_scale
  import vpc_pkg::*;
(
  input  enc_class_e  cls,
  input  dsz_e        dsz,
  input  logic [31:0] raw_disp,
  input  logic [2:0]  elem_log2,
  output logic [31:0] disp
);

  logic [31:0] short_ext;

  assign short_ext = {{24{raw_disp[7]}}, raw_disp[7:0]};

  always_comb begin
    case (dsz)
      DSZ_BYTE: disp = (cls == ENC_EVEX) ? (short_ext << elem_log2) : short_ext;
      DSZ_WORD: disp = raw_disp;
      default:  disp = 32'd0;
    endcase
  end

endmodule

// File: rtl/vec_prefix_classifier.sv
module vec_prefix_classifier
  import vpc_pkg::*;
#(
  parameter int WIN_BYTES = 16,
  parameter int ELEM_W    = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  input  logic [8*WIN_BYTES-1:0] in_win,
  input  logic [ELEM_W-1:0]      in_elem_log2,
  output logic                   out_valid,
  output logic [1:0]             out_class,
  output logic [2:0]             out_pfx_len,
  output logic [2:0]             out_op_off,
  output logic [2:0]             out_disp_size,
  output logic [31:0]            out_disp,
  output logic                   out_hi_bank
);

  pfx_info_t   info;
  dsz_e        dsz;
  logic [31:0] raw_disp;
  logic [31:0] eff_disp;
  logic [2:0]  elem_sh;

  assign elem_sh = 3'(in_elem_log2);

  vpc_prefix_sniff i_sniff (
    .lead_bytes (in_win[15:0]),
    .info       (info)
  );

  vpc_disp_locate #(.WIN_BYTES(WIN_BYTES)) i_locate (
    .win      (in_win),
    .op_off   (info.pfx_len),
    .dsz      (dsz),
    .raw_disp (raw_disp)
  );

  vpc_disp_scale i_scale (
    .cls       (info.cls),
    .dsz       (dsz),
    .raw_disp  (raw_disp),
    .elem_log2 (elem_sh),
    .disp      (eff_disp)
  );

  logic        nxt_valid;
  logic [1:0]  nxt_class;
  logic [2:0]  nxt_pfx_len;
  logic [2:0]  nxt_op_off;
  logic [2:0]  nxt_disp_size;
  logic [31:0] nxt_disp;
  logic        nxt_hi_bank;

  always_comb begin
    nxt_valid     = in_valid;
    nxt_class     = out_class;
    nxt_pfx_len   = out_pfx_len;
    nxt_op_off    = out_op_off;
    nxt_disp_size = out_disp_size;
    nxt_disp      = out_disp;
    nxt_hi_bank   = out_hi_bank;
    if (in_valid) begin
      nxt_class   = info.cls;
      nxt_pfx_len = info.pfx_len;
      nxt_op_off  = info.pfx_len;
      nxt_hi_bank = info.hi_bank;
      nxt_disp    = eff_disp;
      case (dsz)
        DSZ_BYTE: nxt_disp_size = 3'd1;
        DSZ_WORD: nxt_disp_size = 3'd4;
        default:  nxt_disp_size = 3'd0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid     <= 1'b0;
      out_class     <= 2'd0;
      out_pfx_len   <= 3'd0;
      out_op_off    <= 3'd0;
      out_disp_size <= 3'd0;
      out_disp      <= 32'd0;
      out_hi_bank   <= 1'b0;
    end else begin
      out_valid     <= nxt_valid;
      out_class     <= nxt_class;
      out_pfx_len   <= nxt_pfx_len;
      out_op_off    <= nxt_op_off;
      out_disp_size <= nxt_disp_size;
      out_disp      <= nxt_disp;
      out_hi_bank   <= nxt_hi_bank;
    end
  end

  AST_STROBE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid); // R10
  AST_STROBE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid); // R10
  AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(out_disp) && $stable(out_class) && $stable(out_hi_bank))); // R10
  AST_LEGACY_NO_PREFIX: assert property (@(posedge clk) disable iff (!rst_n)
    (out_class == 2'd0) |-> (out_pfx_len == 3'd0 && out_op_off == 3'd0)); // R4
  AST_BANK_NEEDS_EVEX: assert property (@(posedge clk) disable iff (!rst_n)
    out_hi_bank |-> (out_class == 2'd3)); // R9
  AST_NO_DISP_IS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (out_disp_size == 3'd0) |-> (out_disp == 32'd0)); // R5

endmodule

// File: tb/test_vec_prefix_classifier.sv
module test_vec_prefix_classifier;

  localparam int WB = 16;

  logic          clk;
  logic          rst_n;
  logic          in_valid;
  logic [8*WB-1:0] in_win;
  logic [2:0]    in_elem_log2;
  logic          out_valid;
  logic [1:0]    out_class;
  logic [2:0]    out_pfx_len;
  logic [2:0]    out_op_off;
  logic [2:0]    out_disp_size;
  logic [31:0]   out_disp;
  logic          out_hi_bank;

  vec_prefix_classifier #(.WIN_BYTES(WB), .ELEM_W(3)) i_vec_prefix_classifier (
    .clk           (clk),
    .rst_n         (rst_n),
    .in_valid      (in_valid),
    .in_win        (in_win),
    .in_elem_log2  (in_elem_log2),
    .out_valid     (out_valid),
    .out_class     (out_class),
    .out_pfx_len   (out_pfx_len),
    .out_op_off    (out_op_off),
    .out_disp_size (out_disp_size),
    .out_disp      (out_disp),
    .out_hi_bank   (out_hi_bank)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  typedef struct {
    logic [1:0]  cls;
    logic [2:0]  plen;
    logic [2:0]  dsz;
    logic [31:0] disp;
    logic        hi;
    string       tag;
    int          stamp;
  } exp_t;

  exp_t sb[$];
  exp_t last_exp;
  int   cyc = 0;
  int   n_checks = 0;
  int   n_fail = 0;
  bit   done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] expv);
    n_checks++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  // monitor: pops the scoreboard whenever a result appears
  always @(negedge clk) begin
    if (rst_n && out_valid && !done) begin
      if (sb.size() == 0) begin
        chk("R10", "unexpected strobe", 32'd1, 32'd0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        chk(e.tag, "latency R10", 32'(cyc - e.stamp), 32'd1);
        chk(e.tag, "class", 32'(out_class), 32'(e.cls));
        chk(e.tag, "pfx_len", 32'(out_pfx_len), 32'(e.plen));
        chk(e.tag, "op_off", 32'(out_op_off), 32'(e.plen));
        chk(e.tag, "disp_size", 32'(out_disp_size), 32'(e.dsz));
        chk(e.tag, "disp", out_disp, e.disp);
        chk(e.tag, "hi_bank", 32'(out_hi_bank), 32'(e.hi));
        last_exp = e;
      end
    end
  end

  task automatic push_case(input logic [87:0] seq, input int n, input logic [2:0] elem,
                           input logic [1:0] cls, input logic [2:0] plen,
                           input logic [2:0] dsz, input logic [31:0] disp,
                           input logic hi, input string tag);
    logic [8*WB-1:0] w;
    exp_t e;
    w = {WB{8'hCC}};
    for (int i = 0; i < n; i++) w[8*i +: 8] = seq[8*(n-1-i) +: 8];
    @(negedge clk);
    in_valid     = 1'b1;
    in_win       = w;
    in_elem_log2 = elem;
    e.cls = cls; e.plen = plen; e.dsz = dsz; e.disp = disp; e.hi = hi;
    e.tag = tag; e.stamp = cyc;
    sb.push_back(e);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

  initial begin : driver
    rst_n        = 1'b0;
    in_valid     = 1'b0;
    in_win       = '0;
    in_elem_log2 = 3'd0;
    repeat (3) @(negedge clk);
    chk("R10", "reset valid", 32'(out_valid), 32'd0);
    chk("R10", "reset class", 32'(out_class), 32'd0);
    chk("R10", "reset disp", out_disp, 32'd0);
    chk("R10", "reset hi_bank", 32'(out_hi_bank), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10", "idle after reset", 32'(out_valid), 32'd0);

    // back-to-back burst
    push_case({8'hC5,8'h7A,8'h10,8'h3F}, 4, 3'd0, 2'd1, 3'd2, 3'd0, 32'h0, 1'b0, "R1 R5");
    push_case({8'hC4,8'h41,8'h7A,8'h10,8'h3B}, 5, 3'd0, 2'd2, 3'd3, 3'd0, 32'h0, 1'b0, "R2");
    push_case({8'h62,8'hE1,8'h7E,8'h08,8'h10,8'h07}, 6, 3'd2, 2'd3, 3'd4, 3'd0, 32'h0, 1'b1, "R3 R9");
    push_case({8'hC5,8'h7A,8'h10,8'hBF,8'h00,8'h01,8'h00,8'h00}, 8, 3'd2, 2'd1, 3'd2, 3'd4, 32'h100, 1'b0, "R1 R8");
    push_case({8'h62,8'hE1,8'h7E,8'h08,8'h10,8'h47,8'h40}, 7, 3'd2, 2'd3, 3'd4, 3'd1, 32'h100, 1'b1, "R6 R9");
    push_case({8'hC5,8'h78,8'h28,8'hBF,8'h00,8'h01,8'h00,8'h00}, 8, 3'd4, 2'd1, 3'd2, 3'd4, 32'h100, 1'b0, "R8");
    push_case({8'h62,8'hE1,8'h7C,8'h08,8'h28,8'h47,8'h10}, 7, 3'd4, 2'd3, 3'd4, 3'd1, 32'h100, 1'b1, "R6");
    push_case({8'h62,8'hF1,8'h7C,8'h08,8'h28,8'h47,8'h10}, 7, 3'd4, 2'd3, 3'd4, 3'd1, 32'h100, 1'b0, "R6 R9");
    push_case({8'h62,8'hF1,8'h7C,8'h08,8'h28,8'h47,8'hF0}, 7, 3'd4, 2'd3, 3'd4, 3'd1, 32'hFFFFFF00, 1'b0, "R6");
    idle(2);
    // spaced cases
    push_case({8'hC5,8'h7A,8'h10,8'h47,8'hF0}, 5, 3'd4, 2'd1, 3'd2, 3'd1, 32'hFFFFFFF0, 1'b0, "R7");
    idle(1);
    push_case({8'h8B,8'h47,8'h10}, 3, 3'd3, 2'd0, 3'd0, 3'd1, 32'h10, 1'b0, "R4 R7");
    push_case({8'h8B,8'h05,8'h78,8'h56,8'h34,8'h12}, 6, 3'd0, 2'd0, 3'd0, 3'd4, 32'h12345678, 1'b0, "R4 R5");
    idle(1);
    push_case({8'h62,8'hF1,8'h7C,8'h08,8'h28,8'h44,8'h24,8'h02}, 8, 3'd4, 2'd3, 3'd4, 3'd1, 32'h20, 1'b0, "R5 R6");
    push_case({8'h8B,8'h04,8'h25,8'h44,8'h33,8'h22,8'h11}, 7, 3'd0, 2'd0, 3'd0, 3'd4, 32'h11223344, 1'b0, "R5");
    push_case({8'h89,8'hC8}, 2, 3'd2, 2'd0, 3'd0, 3'd0, 32'h0, 1'b0, "R5");
    idle(3);
    push_case({8'h62,8'hF1,8'h7C,8'h08,8'h28,8'h87,8'h00,8'h01,8'h00,8'h00}, 10, 3'd4, 2'd3, 3'd4, 3'd4, 32'h100, 1'b0, "R8");
    push_case({8'hC4,8'hE1,8'h79,8'h6F,8'h47,8'hFF}, 6, 3'd4, 2'd2, 3'd3, 3'd1, 32'hFFFFFFFF, 1'b0, "R2 R7 R9");
    push_case({8'h62,8'hF1,8'h7C,8'h08,8'h28,8'h47,8'h7F}, 7, 3'd0, 2'd3, 3'd4, 3'd1, 32'h7F, 1'b0, "R6");
    push_case({8'h63,8'h47,8'h08}, 3, 3'd4, 2'd0, 3'd0, 3'd1, 32'h8, 1'b0, "R4");
    idle(1);

    // drain the scoreboard
    for (int i = 0; i < 20 && sb.size() != 0; i++) @(negedge clk);
    chk("R10", "scoreboard drained", 32'(sb.size()), 32'd0);

    // garbage with strobe low must not reach the outputs
    in_win       = {WB{8'h62}};
    in_elem_log2 = 3'd7;
    repeat (3) @(negedge clk);
    chk("R10", "hold valid", 32'(out_valid), 32'd0);
    chk("R10", "hold class", 32'(out_class), 32'(last_exp.cls));
    chk("R10", "hold disp", out_disp, last_exp.disp);
    chk("R10", "hold hi_bank", 32'(out_hi_bank), 32'(last_exp.hi));
    chk("R10", "hold disp_size", 32'(out_disp_size), 32'(last_exp.dsz));

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

endmodule